// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter Stage

This block is one synchronous binary counter stage, four bits wide by default. It counts up or down, and a preset value can be loaded into it. All state bits change together on the rising clock edge. Two active-low enables control counting. A separate active-low load takes priority over both of them. A direction input selects incrementing or decrementing.

The stage has a combinational, active-low carry output. This output is asserted at the terminal value for the current direction, and only while the chain enable is active. Several stages can therefore be chained into a wider synchronous counter with no extra gating. Each stage's carry output drives the chain enable of the next stage up. The plain enable, the load and the direction are shared by all stages. Every pin is a plain control or data level, so the block has no streaming handshake and no back-pressure.

An active-low asynchronous reset clears the state, for start-up.

Top module: `ucnt_stage`

## Requirements
- R1: While `rst_n` is low, `count_q` is 0. The clear is asynchronous and does not wait for a clock edge.
- R2: When `load_n` is low at a rising edge, `count_q` takes `data_in` on that edge. The levels of `cnt_en_n` and `chain_en_n` do not matter, and any value from 0 to 2^WIDTH-1 can be loaded.
- R3: When `load_n` is high and either `cnt_en_n` or `chain_en_n` is high at a rising edge, `count_q` keeps its value.
- R4: When `load_n`, `cnt_en_n` and `chain_en_n` are high, low and low, and `dir_up` is 1, `count_q` increments by one on the edge. The all-ones value wraps to 0.
- R5: Under the same enable conditions with `dir_up` at 0, `count_q` decrements by one. Zero wraps to all-ones.
- R6: `carry_out_n` is 0 exactly when `chain_en_n` is 0 and `count_q` is at terminal count: all ones with `dir_up`=1, or all zeros with `dir_up`=0. It follows these inputs in the same cycle, with no register between them.
- R7: `cnt_en_n` has no influence on `carry_out_n`.
- R8: While the stage counts freely, bit k of `count_q` changes exactly on edges where the number of counted edges since 0 is a multiple of 2^k. Bit k thus runs at 1/2^(k+1) of the clock rate.
- R9: Two stages form a 2*WIDTH-bit up/down counter, including loads and wrap. In the chain, the lower stage's `carry_out_n` drives the upper stage's `chain_en_n`, and all other controls are shared. The upper stage's `carry_out_n` marks the terminal count of the whole chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low; overrides both enables |
| cnt_en_n | input | 1 | Count enable, active low; does not affect the carry output |
| chain_en_n | input | 1 | Count enable, active low, that also qualifies the carry output |
| dir_up | input | 1 | 1 selects counting up, 0 selects counting down |
| data_in | input | WIDTH | Preset value |
| count_q | output | WIDTH | Current count |
| carry_out_n | output | 1 | Terminal-count flag, active low, combinational |

## Verification
The bench builds two stages at the default WIDTH of 4 and chains them into an 8-bit counter. At this size the whole 256-value range is short enough to cross, so both wrap directions are reached in a few cycles from nearby presets. A run of a few hundred cycles also covers every terminal-count state of both stages, in both directions. The lower stage's four bits are long enough to show the divide-by-2, 4, 8 and 16 toggle pattern, and the chained carry puts look-ahead propagation across a stage boundary under test on every cycle.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  // Action applied to the state register on the next rising edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } ucnt_op_e;

endpackage

// File: rtl/ucnt_ctrl.sv
module ucnt_ctrl
  import ucnt_pkg::*;
(
  input  logic     load_n,
  input  logic     cnt_en_n,
  input  logic     chain_en_n,
  input  logic     dir_up,
  output ucnt_op_e op
);

  logic advance;

  // Counting needs both enables low; the preset wins over everything.
  assign advance = ~cnt_en_n & ~chain_en_n;

  always_comb begin
    if (!load_n) begin
      op = OP_LOAD;
    end else if (advance) begin
      op = dir_up ? OP_INC : OP_DEC;
    end else begin
      op = OP_HOLD;
    end
  end

endmodule

// File: rtl/ucnt_next.sv
module ucnt_next
  import ucnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ucnt_op_e         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);

  // Bit k toggles when every lower bit is 1 (counting up) or 0 (counting
  // down). All toggles are resolved in parallel, so every bit updates on
  // the same edge.
  logic [WIDTH-1:0] low_ones;
  logic [WIDTH-1:0] low_zeros;
  logic [WIDTH-1:0] flip;

  assign low_ones[0]  = 1'b1;
  assign low_zeros[0] = 1'b1;

  generate
    for (genvar k = 1; k < WIDTH; k++) begin : g_chain
      assign low_ones[k]  = low_ones[k-1]  &  cur[k-1];
      assign low_zeros[k] = low_zeros[k-1] & ~cur[k-1];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_INC:  flip = low_ones;
      OP_DEC:  flip = low_zeros;
      default: flip = '0;
    endcase
  end

  assign nxt = (op == OP_LOAD) ? preset : (cur ^ flip);

endmodule

// File: rtl/ucnt_term.sv
module ucnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_up,
  input  logic             chain_en_n,
  output logic             carry_out_n
);

  logic at_top;
  logic at_bottom;
  logic at_end;

  assign at_top      = &cur;
  assign at_bottom   = ~|cur;
  assign at_end      = dir_up ? at_top : at_bottom;
  // Only the chain enable qualifies the flag, so the next stage up sees it
  // within the same cycle.
  assign carry_out_n = ~(at_end & ~chain_en_n);

endmodule

// File: rtl/ucnt_stage.sv
module ucnt_stage
  import ucnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count_q,
  output logic             carry_out_n
);

  ucnt_op_e         op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  ucnt_ctrl u_ctrl (
    .load_n     (load_n),
    .cnt_en_n   (cnt_en_n),
    .chain_en_n (chain_en_n),
    .dir_up     (dir_up),
    .op         (op)
  );

  ucnt_next #(.WIDTH(WIDTH)) u_next (
    .op     (op),
    .cur    (state_q),
    .preset (data_in),
    .nxt    (state_d)
  );

  ucnt_term #(.WIDTH(WIDTH)) u_term (
    .cur         (state_q),
    .dir_up      (dir_up),
    .chain_en_n  (chain_en_n),
    .carry_out_n (carry_out_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign count_q = state_q;

endmodule

// File: rtl/ucnt_stage_chk.sv
module ucnt_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             cnt_en_n,
  input logic             chain_en_n,
  input logic             dir_up,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] count_q,
  input logic             carry_out_n
);

  always_comb begin
    if (!rst_n) begin
      assert_clear_R1: assert (count_q == '0)
        else $error("count not cleared during reset");
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count_q == $past(data_in));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (cnt_en_n || chain_en_n)) |=> $stable(count_q));

  assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && !chain_en_n && dir_up)
      |=> count_q == WIDTH'($past(count_q) + 1'b1));

  assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && !chain_en_n && !dir_up)
      |=> count_q == WIDTH'($past(count_q) - 1'b1));

  assert_flag_needs_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_out_n |-> (!chain_en_n &&
                      ((dir_up && (&count_q)) || (!dir_up && count_q == '0))));

  assert_end_gives_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en_n && ((dir_up && (&count_q)) || (!dir_up && count_q == '0)))
      |-> !carry_out_n);

endmodule

bind ucnt_stage ucnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_n      (load_n),
  .cnt_en_n    (cnt_en_n),
  .chain_en_n  (chain_en_n),
  .dir_up      (dir_up),
  .data_in     (data_in),
  .count_q     (count_q),
  .carry_out_n (carry_out_n)
);

// File: tb/tb_ucnt_stage.sv
module tb_ucnt_stage;

  localparam int PERIOD = 10;
  localparam int W      = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en_n = 1'b1;
  logic         chain_en_n = 1'b1;
  logic         dir_up = 1'b1;
  logic [7:0]   data8 = '0;
  logic [W-1:0] q_lo, q_hi;
  logic         co_lo, co_hi;

  int checks = 0;
  int fails  = 0;
  int model  = 0;

  always #(PERIOD/2) clk = ~clk;

  ucnt_stage #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .chain_en_n(chain_en_n), .dir_up(dir_up), .data_in(data8[3:0]),
    .count_q(q_lo), .carry_out_n(co_lo)
  );

  ucnt_stage #(.WIDTH(W)) dut_hi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .chain_en_n(co_lo), .dir_up(dir_up), .data_in(data8[7:4]),
    .count_q(q_hi), .carry_out_n(co_hi)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int flag_exp(input int val, input int top);
    if (!chain_en_n && ((dir_up && val == top) || (!dir_up && val == 0)))
      return 0;
    return 1;
  endfunction

  // Compare both stages with the behavioural model (called at negedge).
  task automatic compare_all();
    check({q_hi, q_lo}, model, "R9 chained count");
    check(q_lo, model % 16, "R4/R5 low stage count");
    check(co_lo, flag_exp(model % 16, 15), "R6 low carry");
    check(co_hi, flag_exp(model, 255), "R9 chain carry");
  endtask

  // One clock: inputs already set away from the edge, model advanced after it.
  task automatic step();
    @(posedge clk);
    if (!load_n) model = int'(data8);
    else if (!cnt_en_n && !chain_en_n) model = dir_up ? (model + 1) % 256
                                                      : (model + 255) % 256;
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input logic ld, input logic en, input logic ce,
                       input logic up, input logic [7:0] d);
    load_n = ld; cnt_en_n = en; chain_en_n = ce; dir_up = up; data8 = d;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    @(negedge clk);
    check(q_lo, 0, "R1 reset low stage");
    check(q_hi, 0, "R1 reset high stage");
    #(PERIOD/4) rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // Free up-count from 0: toggle pattern of the low stage (R8).
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    prev = q_lo;
    for (int n = 1; n <= 40; n++) begin
      step();
      for (int k = 0; k < W; k++) begin
        check(int'(q_lo[k] != prev[k]), int'((n % (1 << k)) == 0), "R8 bit toggle");
      end
      prev = q_lo;
    end

    // Load while enables are inactive, then while active (R2).
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
    step();
    check(q_lo, 5, "R2 load with enables high");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
    step();
    check(q_lo, 12, "R2 load with enables low");

    // Hold with each enable inactive (R3).
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 3; i++) step();
    check({q_hi, q_lo}, 8'h3C, "R3 hold plain enable high");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 3; i++) step();
    check({q_hi, q_lo}, 8'h3C, "R3 hold chain enable high");

    // Up wrap through 0xFF (R4).
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hFD);
    step();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 4; i++) step();
    check({q_hi, q_lo}, 8'h01, "R4 up wrap");

    // Down wrap through 0 (R5).
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h02);
    step();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) step();
    check({q_hi, q_lo}, 8'hFD, "R5 down wrap");

    // Plain enable does not move the carry (R7).
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h0F);
    step();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    #1 check(co_lo, 0, "R7 carry with plain enable high");
    cnt_en_n = 1'b0;
    #1 check(co_lo, 0, "R7 carry with plain enable low");
    chain_en_n = 1'b1;
    #1 check(co_lo, 1, "R6 carry gated by chain enable");
    dir_up = 1'b0;
    chain_en_n = 1'b0;
    #1 check(co_lo, 1, "R6 carry follows direction");
    cnt_en_n = 1'b1;
    step();

    // Mixed random traffic on the chain (R9).
    for (int i = 0; i < 400; i++) begin
      drive(($urandom_range(0, 9) != 0), logic'($urandom_range(0, 3) == 0),
            logic'($urandom_range(0, 4) == 0), logic'($urandom_range(0, 1)),
            8'($urandom_range(0, 255)));
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule